// File: doc/BRIEF.md
# Condition Predicate Gate

This block decides, once per cycle, whether an instruction is allowed to take effect. It takes the 4-bit condition field of the instruction and compares it against four architectural flags: negative (N), zero (Z), carry (C) and overflow (V). It produces a single pass bit. A pass bit of 0 means the instruction is to be squashed. The block also raises a separate indication when the field holds the reserved code.

The flags live in a small register inside the block. A flag-producing stage writes the register through a write enable. An instruction presented in the cycle after a write is judged against the new flags, which matches a pipeline in which the flag update retires one stage ahead of the predicate check. The predicate logic itself is purely combinational from the condition field and the stored flags. A parameter chooses between two ways of building it: a paired decode that shares one predicate per code pair, or a flat sixteen-way decode.

Top module: `cond_gate_unit`

## Requirements
- R1: While rst_ni is low, and after it is released, the stored flags are all zero until the first write. With those flags, code 1 (not equal) passes and code 0 (equal) fails.
- R2: flags_i is taken into the stored flags at a rising clock edge when flag_we_i is 1, and is judged from the next cycle on. While flag_we_i is 0, the stored flags keep their value whatever flags_i carries. Bit order: flags_i[3]=N, [2]=Z, [1]=C, [0]=V.
- R3: Code 0 passes when Z=1. Code 1 passes when Z=0.
- R4: Code 2 (unsigned higher or same) passes when C=1. Code 3 (unsigned lower) passes when C=0.
- R5: Code 4 passes when N=1. Code 5 passes when N=0.
- R6: Code 6 passes when V=1. Code 7 passes when V=0.
- R7: Code 8 (unsigned higher) passes when C=1 and Z=0. Code 9 (unsigned lower or same) passes when C=0 or Z=1.
- R8: Code 10 (signed greater or equal) passes when N equals V. Code 11 (signed less) passes when N differs from V.
- R9: Code 12 (signed greater) passes when Z=0 and N equals V. Code 13 (signed less or equal) passes when Z=1 or N differs from V.
- R10: Code 14 passes for every flag value.
- R11: Code 15 (reserved) never passes and drives reserved_o to 1. reserved_o is 0 for every other code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flag_we_i | input | 1 | Write enable for the stored flags |
| flags_i | input | 4 | New flag values {N,Z,C,V} |
| cond_i | input | 4 | Condition field of the current instruction |
| pass_o | output | 1 | 1 when the instruction executes |
| reserved_o | output | 1 | 1 when cond_i holds the reserved code |

## Verification
The case that is hardest to reach from the ports is a predicate evaluated against stored flags that differ from what flags_i currently carries. In that case a design that wrongly reads flags_i straight through would still look correct whenever the two happen to match. To reach it, the stimulus writes each of the sixteen flag patterns and then drops the write enable. It then drives the bitwise complement on flags_i while sweeping all sixteen codes. Every code is therefore checked once with matching inputs and once with contradicting inputs. A mid-run asynchronous reset checks that the stored flags are cleared.

// File: rtl/cond_pkg.sv
package cond_pkg;
  localparam int unsigned COND_W = 4;
  localparam int unsigned FLAG_W = 4;

  typedef enum logic [COND_W-1:0] {
    C_EQ = 4'd0,  C_NE = 4'd1,  C_HS = 4'd2,  C_LO = 4'd3,
    C_NEG = 4'd4, C_POS = 4'd5, C_OVF = 4'd6, C_NOV = 4'd7,
    C_UHI = 4'd8, C_ULS = 4'd9, C_SGE = 4'd10, C_SLT = 4'd11,
    C_SGT = 4'd12, C_SLE = 4'd13, C_ALW = 4'd14, C_RSV = 4'd15
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/cond_flag_reg.sv
module cond_flag_reg
  import cond_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   we_i,
  input  flags_t d_i,
  output flags_t q_o
);
  flags_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (we_i) q <= d_i;
  end

  assign q_o = q;

  p_flags_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> q_o == $past(d_i));
  p_flags_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import cond_pkg::*;
#(
  parameter bit PAIRED = 1'b1
) (
  input  logic [COND_W-1:0] cond_i,
  input  flags_t            flg_i,
  output logic              pass_o,
  output logic              rsv_o
);
  localparam int unsigned SEL_W = COND_W - 1;

  logic nv_eq;
  assign nv_eq = (flg_i.n == flg_i.v);
  assign rsv_o = (cond_i == C_RSV);

  generate
    if (PAIRED) begin : g_paired
      // one predicate per code pair, odd code is its complement
      logic [SEL_W-1:0] sel;
      logic             base;
      assign sel = cond_i[COND_W-1:1];
      always_comb begin
        unique case (sel)
          3'd0: base = flg_i.z;
          3'd1: base = flg_i.c;
          3'd2: base = flg_i.n;
          3'd3: base = flg_i.v;
          3'd4: base = flg_i.c & ~flg_i.z;
          3'd5: base = nv_eq;
          3'd6: base = ~flg_i.z & nv_eq;
          default: base = 1'b1;
        endcase
      end
      assign pass_o = base ^ cond_i[0];
    end else begin : g_flat
      always_comb begin
        unique case (cond_e'(cond_i))
          C_EQ:  pass_o = flg_i.z;
          C_NE:  pass_o = ~flg_i.z;
          C_HS:  pass_o = flg_i.c;
          C_LO:  pass_o = ~flg_i.c;
          C_NEG: pass_o = flg_i.n;
          C_POS: pass_o = ~flg_i.n;
          C_OVF: pass_o = flg_i.v;
          C_NOV: pass_o = ~flg_i.v;
          C_UHI: pass_o = flg_i.c & ~flg_i.z;
          C_ULS: pass_o = ~flg_i.c | flg_i.z;
          C_SGE: pass_o = nv_eq;
          C_SLT: pass_o = ~nv_eq;
          C_SGT: pass_o = ~flg_i.z & nv_eq;
          C_SLE: pass_o = flg_i.z | ~nv_eq;
          C_ALW: pass_o = 1'b1;
          default: pass_o = 1'b0;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/cond_gate_unit.sv
module cond_gate_unit
  import cond_pkg::*;
#(
  parameter bit PAIRED = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flag_we_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [COND_W-1:0] cond_i,
  output logic              pass_o,
  output logic              reserved_o
);
  flags_t flg_q;

  cond_flag_reg u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (flag_we_i),
    .d_i   (flags_t'(flags_i)),
    .q_o   (flg_q)
  );

  cond_eval #(.PAIRED(PAIRED)) u_eval (
    .cond_i(cond_i),
    .flg_i (flg_q),
    .pass_o(pass_o),
    .rsv_o (reserved_o)
  );

  p_reserved_blocks_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == C_RSV) |-> (!pass_o && reserved_o));
  p_reserved_only_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i != C_RSV) |-> !reserved_o);
  p_always_passes_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == C_ALW) |-> pass_o);
  p_eq_follows_z_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == C_EQ) |-> (pass_o == flg_q.z));
  p_write_visible_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && cond_i == C_NEG && $stable(cond_i)) |=>
      (cond_i != C_NEG) || (pass_o == $past(flags_i[3])));
endmodule

// File: tb/cond_gate_unit_test.sv
module cond_gate_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [3:0] fl = 4'h0;
  logic [3:0] cc = 4'h0;
  logic       pass, rsv;

  int checks = 0;
  int errors = 0;
  logic [3:0] model_flags = 4'h0;
  bit done = 0;

  always #4 clk = ~clk;

  cond_gate_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .flag_we_i(we),
    .flags_i(fl), .cond_i(cc), .pass_o(pass), .reserved_o(rsv)
  );

  function automatic bit expect_pass(input logic [3:0] code, input logic [3:0] f);
    bit n, z, c, v;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    case (code)
      0:  return z;
      1:  return !z;
      2:  return c;
      3:  return !c;
      4:  return n;
      5:  return !n;
      6:  return v;
      7:  return !v;
      8:  return c && !z;
      9:  return !c || z;
      10: return n == v;
      11: return n != v;
      12: return !z && (n == v);
      13: return z || (n != v);
      14: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] code);
    case (code)
      0, 1:   return "R3";
      2, 3:   return "R4";
      4, 5:   return "R5";
      6, 7:   return "R6";
      8, 9:   return "R7";
      10, 11: return "R8";
      12, 13: return "R9";
      14:     return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic compare(input string tag);
    bit ep, er;
    ep = expect_pass(cc, model_flags);
    er = (cc == 4'hF);
    checks++;
    if (pass !== ep || rsv !== er) begin
      errors++;
      $display("FAIL %s code=%0d flags=%b pass=%b rsv=%b expected pass=%b rsv=%b",
               tag, cc, model_flags, pass, rsv, ep, er);
    end
  endtask

  // drive at negedge, model updates at posedge, compare at following negedge
  task automatic step(input logic w, input logic [3:0] f, input logic [3:0] c, input string tag);
    we = w; fl = f; cc = c;
    @(posedge clk);
    if (rst_n && w) model_flags = f;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    for (int c = 0; c < 16; c++) begin
      cc = c[3:0];
      #1;
      compare("R1");
    end
    rst_n = 1'b1;
    @(negedge clk);
    step(1'b0, 4'hF, 4'd1, "R1");
    step(1'b0, 4'hF, 4'd0, "R1");

    // R2 plus every predicate: write pattern, then sweep codes with complemented inputs
    for (int f = 0; f < 16; f++) begin
      step(1'b1, f[3:0], 4'd14, "R2");
      for (int c = 0; c < 16; c++)
        step(1'b0, ~f[3:0], c[3:0], {"R2,", tag_of(c[3:0])});
    end

    // back-to-back writes, each visible the next cycle
    for (int f = 0; f < 16; f++)
      step(1'b1, 4'(15 - f), 4'(f), {"R2,", tag_of(4'(f))});

    // R1: async reset clears flags mid-run
    step(1'b1, 4'hF, 4'd0, "R2");
    #1 rst_n = 1'b0;
    model_flags = 4'h0;
    #1;
    cc = 4'd0; #1 compare("R1");
    cc = 4'd1; #1 compare("R1");
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 4'hF, 4'd3, "R1");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule